// File: doc/BRIEF.md
# Lane Register Write Buffer with Gated Upper Region

This block sits beside one thread lane's slow non-volatile register array and absorbs every register write made while a warp is active. A direct-mapped map table holds, for each architectural register, a valid flag and the number of the buffer entry that carries the latest value. A write to a register that is already buffered replaces that entry. A write to a register that is not buffered takes the next free entry and records its register number. A read looks up the table in the same cycle as the backing array is read, and returns buffer data on a hit or the array's data otherwise.

Entries are handed out in strict order, so the live entries always form a run from entry 0. The lowest entries are always powered. The rest form an upper region held behind a power switch. A small state machine has three states. LOW_ONLY is the reset state, with the switch open. WAKING has a request raised and waits for power-good. UPPER_ON allows the upper region to be used. The transition `wake` leads from LOW_ONLY to WAKING when a write first needs an upper entry. The transition `settle` leads from WAKING to UPPER_ON when power-good is seen. The transition `release` leads from any state back to LOW_ONLY when the buffer is cleared for a new warp, which happens once its contents have been written back. A drain port reads the live entries by index so that an outside sequencer can copy them into the array. It flags the end of the run.

Top module: `lane_write_buffer`

## Requirements
- R1: After reset every read misses and returns `arr_rd_data`, `drain_done` is high at index 0, `pwr_req` is low and `wr_ready` is high.
- R2: A write to a register with no valid map slot stores its data and 6-bit register number at the entry equal to the current occupancy, then occupancy rises by one. `drain_data`/`drain_reg` at that index show the stored pair from the next cycle.
- R3: A write to a register that is already buffered replaces the data in its existing entry and leaves occupancy unchanged.
- R4: A read of a buffered register returns the buffer data in the same cycle. A read of any other register returns `arr_rd_data` unchanged.
- R5: A read of a register in the cycle it is written returns the value held before that write. The new value appears from the next cycle.
- R6: `warp_start` empties the map table and sets occupancy to zero. A write in the same cycle is applied to the emptied buffer and lands in entry 0.
- R7: Allocations into entries 0 to 15 never raise `pwr_req` and never stall.
- R8: A write that needs entry 16 or above while the state is LOW_ONLY drops `wr_ready` and raises `pwr_req` in that same cycle. In WAKING the write completes in the first cycle in which `pwr_good` is high.
- R9: Once raised, `pwr_req` stays high until `warp_start`. It is low in the cycle after `warp_start`.
- R10: `drain_done` is high exactly when `drain_idx` is greater than or equal to the occupancy.
- R11: A write held while `wr_ready` is low changes neither occupancy nor buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_start | input | 1 | Clear the buffer for a newly activated warp |
| wr_en | input | 1 | Register write request |
| wr_reg | input | 6 | Register number to write |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Low while a write waits for upper-region power |
| rd_reg | input | 6 | Register number to read |
| arr_rd_data | input | 32 | Data read in parallel from the backing array |
| rd_data | output | 32 | Read result (buffer on hit, array on miss) |
| pwr_req | output | 1 | Request to close the upper-region power switch |
| pwr_good | input | 1 | Upper region is powered and usable |
| drain_idx | input | 6 | Entry index for write-back |
| drain_data | output | 32 | Data of the entry at `drain_idx` |
| drain_reg | output | 6 | Register number of the entry at `drain_idx` |
| drain_done | output | 1 | `drain_idx` is at or past the last live entry |

## Verification
Two pairs of functions can fall in the same cycle. The first is a read and a write of the same register. Vectors put the read address equal to the write address, both for a register that is not yet buffered and for one that is. The expected read value is the value held before the write: array data in the first case and the older buffer value in the second. The next vector checks that the new value has arrived. The second pair is `warp_start` together with a write. After that cycle, the drain port must show that write alone at entry 0, and an earlier register must read back as a miss.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    typedef enum logic [1:0] {
        LOW_ONLY = 2'd0,
        WAKING   = 2'd1,
        UPPER_ON = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/lwb_map_table.sv
module lwb_map_table #(
    parameter int NREG  = 64,
    parameter int IDX_W = 6,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [REG_W-1:0] wr_look_reg,
    output logic             wr_look_hit,
    output logic [IDX_W-1:0] wr_look_idx,
    input  logic [REG_W-1:0] rd_look_reg,
    output logic             rd_look_hit,
    output logic [IDX_W-1:0] rd_look_idx
);
    logic [NREG-1:0]  valid_q;
    logic [IDX_W-1:0] slot_idx_q [NREG];

    // Later assignment wins: a set in the clearing cycle survives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (clear)  valid_q <= '0;
            if (set_en) valid_q[set_reg] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) slot_idx_q[set_reg] <= set_idx;
    end

    always_comb begin
        wr_look_hit = valid_q[wr_look_reg];
        wr_look_idx = slot_idx_q[wr_look_reg];
        rd_look_hit = valid_q[rd_look_reg];
        rd_look_idx = slot_idx_q[rd_look_reg];
    end
endmodule

// File: rtl/lwb_entry_store.sv
module lwb_entry_store #(
    parameter int NENT   = 64,
    parameter int DATA_W = 32,
    parameter int REG_W  = 6,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_tag,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [REG_W-1:0]  w_reg,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    output logic [REG_W-1:0]  rb_reg
);
    logic [DATA_W-1:0] data_q [NENT];
    logic [REG_W-1:0]  tag_q  [NENT];

    always_ff @(posedge clk) begin
        if (we) data_q[w_idx] <= w_data;
        if (we && we_tag) tag_q[w_idx] <= w_reg;
    end

    always_comb begin
        ra_data = data_q[ra_idx];
        rb_data = data_q[rb_idx];
        rb_reg  = tag_q[rb_idx];
    end
endmodule

// File: rtl/lwb_power_ctrl.sv
module lwb_power_ctrl
    import lwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic need_upper,
    input  logic pwr_good,
    output logic pwr_req,
    output logic upper_ok,
    output logic upper_on
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOW_ONLY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOW_ONLY: if (need_upper) state_d = WAKING;   // wake
            WAKING:   if (pwr_good)   state_d = UPPER_ON; // settle
            UPPER_ON: state_d = UPPER_ON;
            default:  state_d = LOW_ONLY;
        endcase
        if (clear) state_d = LOW_ONLY;                    // release
    end

    always_comb begin
        pwr_req  = 1'b0;
        upper_ok = 1'b0;
        upper_on = 1'b0;
        unique case (state_q)
            LOW_ONLY: pwr_req = need_upper;
            WAKING: begin
                pwr_req  = 1'b1;
                upper_ok = pwr_good;
            end
            UPPER_ON: begin
                pwr_req  = 1'b1;
                upper_ok = 1'b1;
                upper_on = 1'b1;
            end
            default: pwr_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_write_buffer.sv
module lane_write_buffer #(
    parameter int DATA_W  = 32,
    parameter int NREG    = 64,
    parameter int NENT    = 64,
    parameter int LOW_ENT = 16,
    localparam int REG_W = $clog2(NREG),
    localparam int IDX_W = $clog2(NENT),
    localparam int CNT_W = $clog2(NENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warp_start,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [REG_W-1:0]  rd_reg,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwr_req,
    input  logic              pwr_good,
    input  logic [IDX_W-1:0]  drain_idx,
    output logic [DATA_W-1:0] drain_data,
    output logic [REG_W-1:0]  drain_reg,
    output logic              drain_done
);
    logic [CNT_W-1:0]  count_q, cnt_eff;
    logic              wr_hit, rd_hit, wr_hit_eff;
    logic [IDX_W-1:0]  wr_idx, rd_idx, w_idx;
    logic              need_alloc, need_upper, upper_ok, upper_on, stall, do_write;
    logic [DATA_W-1:0] buf_rd_data;

    always_comb begin
        wr_hit_eff = wr_hit && !warp_start;
        cnt_eff    = warp_start ? '0 : count_q;
        need_alloc = wr_en && !wr_hit_eff;
        need_upper = need_alloc && (cnt_eff >= CNT_W'(LOW_ENT));
        stall      = need_upper && !upper_ok;
        do_write   = wr_en && !stall;
        w_idx      = wr_hit_eff ? wr_idx : cnt_eff[IDX_W-1:0];
        wr_ready   = !stall;
        rd_data    = rd_hit ? buf_rd_data : arr_rd_data;
        drain_done = CNT_W'(drain_idx) >= count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= cnt_eff + CNT_W'(do_write && need_alloc);
    end

    lwb_map_table #(.NREG(NREG), .IDX_W(IDX_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clear(warp_start),
        .set_en(do_write && need_alloc), .set_reg(wr_reg), .set_idx(w_idx),
        .wr_look_reg(wr_reg), .wr_look_hit(wr_hit), .wr_look_idx(wr_idx),
        .rd_look_reg(rd_reg), .rd_look_hit(rd_hit), .rd_look_idx(rd_idx)
    );

    lwb_entry_store #(.NENT(NENT), .DATA_W(DATA_W), .REG_W(REG_W)) u_store (
        .clk(clk), .we(do_write), .we_tag(need_alloc), .w_idx(w_idx),
        .w_data(wr_data), .w_reg(wr_reg),
        .ra_idx(rd_idx), .ra_data(buf_rd_data),
        .rb_idx(drain_idx), .rb_data(drain_data), .rb_reg(drain_reg)
    );

    lwb_power_ctrl u_pwr (
        .clk(clk), .rst_n(rst_n), .clear(warp_start), .need_upper(need_upper),
        .pwr_good(pwr_good), .pwr_req(pwr_req), .upper_ok(upper_ok), .upper_on(upper_on)
    );
endmodule

// File: rtl/lwb_checker.sv
module lwb_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             warp_start,
    input logic             wr_en,
    input logic             wr_ready,
    input logic             pwr_req,
    input logic             pwr_good,
    input logic             upper_on,
    input logic [CNT_W-1:0] count
);
    p_stall_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> pwr_req);

    p_on_after_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upper_on) |-> $past(pwr_good));

    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req && !warp_start) |=> pwr_req);

    p_req_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warp_start |=> !pwr_req);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !warp_start |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready && !warp_start) |=> count == $past(count));
endmodule

bind lane_write_buffer lwb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .warp_start(warp_start), .wr_en(wr_en),
    .wr_ready(wr_ready), .pwr_req(pwr_req), .pwr_good(pwr_good),
    .upper_on(upper_on), .count(count_q)
);

// File: tb/sim_lane_write_buffer.sv
module sim_lane_write_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {wr_en, wr_reg[6], wr_data[32], rd_reg[6], arr[32], exp_rd[32]}
    localparam logic [108:0] VEC [NV] = '{
        {1'b1, 6'd5, 32'h0000_1111, 6'd5, 32'h0000_AAAA, 32'h0000_AAAA},
        {1'b0, 6'd0, 32'h0,         6'd5, 32'h0000_BBBB, 32'h0000_1111},
        {1'b1, 6'd9, 32'h0000_2222, 6'd7, 32'h0000_CCCC, 32'h0000_CCCC},
        {1'b1, 6'd5, 32'h0000_3333, 6'd5, 32'h0000_DDDD, 32'h0000_1111},
        {1'b0, 6'd0, 32'h0,         6'd5, 32'h0000_EEEE, 32'h0000_3333},
        {1'b0, 6'd0, 32'h0,         6'd9, 32'h0000_0000, 32'h0000_2222}
    };

    logic clk = 1'b0, rst_n = 1'b0, warp_start = 1'b0, wr_en = 1'b0, pwr_good = 1'b0;
    logic [5:0] wr_reg = '0, rd_reg = '0, drain_idx = '0;
    logic [31:0] wr_data = '0, arr_rd_data = '0;
    logic wr_ready, pwr_req, drain_done;
    logic [31:0] rd_data, drain_data;
    logic [5:0] drain_reg;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_write_buffer u0 (
        .clk(clk), .rst_n(rst_n), .warp_start(warp_start), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_data(wr_data), .wr_ready(wr_ready), .rd_reg(rd_reg),
        .arr_rd_data(arr_rd_data), .rd_data(rd_data), .pwr_req(pwr_req),
        .pwr_good(pwr_good), .drain_idx(drain_idx), .drain_data(drain_data),
        .drain_reg(drain_reg), .drain_done(drain_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic drain_at(input logic [5:0] idx, input logic [5:0] reg_e,
                            input logic [31:0] data_e, input string req);
        drain_idx = idx;
        #1;
        chk(req, {31'd0, drain_done}, 32'd0);
        chk(req, {26'd0, drain_reg}, {26'd0, reg_e});
        chk(req, drain_data, data_e);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_reg = 6'd3; arr_rd_data = 32'h0000_1234; drain_idx = 6'd0;
        #1;
        chk("R1 rd miss", rd_data, 32'h0000_1234);
        chk("R1 done", {31'd0, drain_done}, 32'd1);
        chk("R1 req", {31'd0, pwr_req}, 32'd0);
        chk("R1 ready", {31'd0, wr_ready}, 32'd1);
        @(negedge clk); rst_n = 1'b1;

        // R4 R5 R3 vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {wr_en, wr_reg, wr_data, rd_reg, arr_rd_data} = VEC[i][108:32];
            #1;
            chk($sformatf("R4/R5 vec%0d", i), rd_data, VEC[i][31:0]);
        end
        next_cycle(); wr_en = 1'b0;
        // R2 R3: drain contents, R10 done flag
        drain_at(6'd0, 6'd5, 32'h0000_3333, "R3 drain0");
        drain_at(6'd1, 6'd9, 32'h0000_2222, "R2 drain1");
        drain_idx = 6'd2; #1;
        chk("R10 done at count", {31'd0, drain_done}, 32'd1);

        // R6: warp_start with write
        next_cycle();
        warp_start = 1'b1; wr_en = 1'b1; wr_reg = 6'd40; wr_data = 32'h0000_5555;
        next_cycle();
        warp_start = 1'b0; wr_en = 1'b0;
        drain_at(6'd0, 6'd40, 32'h0000_5555, "R6 entry0");
        drain_idx = 6'd1; rd_reg = 6'd5; arr_rd_data = 32'h0000_9999; #1;
        chk("R6 done1", {31'd0, drain_done}, 32'd1);
        chk("R6 cleared miss", rd_data, 32'h0000_9999);

        // R7: fill entries 0..15
        warp_start = 1'b1;
        next_cycle();
        warp_start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            wr_en = 1'b1; wr_reg = 6'(i); wr_data = 32'h100 + 32'(i);
            #1;
            chk($sformatf("R7 ready e%0d", i), {31'd0, wr_ready}, 32'd1);
            chk($sformatf("R7 req e%0d", i), {31'd0, pwr_req}, 32'd0);
            next_cycle();
        end
        // R8: entry 16 needs power
        wr_reg = 6'd20; wr_data = 32'h0000_7777; pwr_good = 1'b0; drain_idx = 6'd16;
        #1;
        chk("R8 stall", {31'd0, wr_ready}, 32'd0);
        chk("R8 req", {31'd0, pwr_req}, 32'd1);
        next_cycle();
        chk("R11 no alloc", {31'd0, drain_done}, 32'd1);
        chk("R8 still stalled", {31'd0, wr_ready}, 32'd0);
        pwr_good = 1'b1; #1;
        chk("R8 granted", {31'd0, wr_ready}, 32'd1);
        next_cycle();
        wr_en = 1'b0;
        drain_at(6'd16, 6'd20, 32'h0000_7777, "R8 entry16");
        drain_at(6'd15, 6'd15, 32'h0000_010F, "R11 entry15 intact");
        // R9: stays on, then released
        wr_en = 1'b1; wr_reg = 6'd21; wr_data = 32'h0000_8888; #1;
        chk("R9 ready on", {31'd0, wr_ready}, 32'd1);
        next_cycle();
        wr_en = 1'b0; #1;
        chk("R9 req held", {31'd0, pwr_req}, 32'd1);
        warp_start = 1'b1;
        next_cycle();
        warp_start = 1'b0; drain_idx = 6'd0; #1;
        chk("R9 req dropped", {31'd0, pwr_req}, 32'd0);
        chk("R9 empty", {31'd0, drain_done}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule